// File: doc/BRIEF.md
# SHA-1 Block Compression Core

This core applies the SHA-1 compression function to one 512-bit message block. It holds a 160-bit chaining value. When a block is started, the chaining value is copied into five working words. The core runs one round per clock for 80 rounds. It then adds the working words back into the chaining value. The host hashes a message by first setting the chaining value, either to the standard initial constants or to a value of its own. It then presents each complete, already padded block in turn. After the last block, it reads the digest from the chaining-value output. Padding, length encoding and cutting a byte stream into blocks are the host's job.

The schedule words are never stored as an 80-entry table. A 16-word circular window holds the message. In each round it provides the current schedule word and overwrites the slot it has just read with that word.

The controller is a four-state machine:
- **IDLE**: waiting for work.
- **ROUND**: one compression round per cycle.
- **FINAL**: the feed-forward addition.
- **DONE**: a one-cycle completion state that also accepts work.

Transitions:
- IDLE→ROUND and DONE→ROUND on an accepted start.
- ROUND→ROUND while the round index is below 79.
- ROUND→FINAL after round 79.
- FINAL→DONE always.
- DONE→IDLE when no start is present.

Top module: `sha1_compress_core`

## Requirements
- R1: The block input is sixteen 32-bit words. Word 0 is `block_i[511:480]` and word 15 is `block_i[31:0]`, so the first message byte is the most significant byte of word 0.
- R2: Schedule word i equals message word i for i below 16. For later rounds it is the XOR of words i-3, i-8, i-14 and i-16, rotated left by one bit.
- R3: The round function is the choose function D^(B&(C^D)) in rounds 0 to 19, majority (B&C)|(D&(B^C)) in rounds 40 to 59, and the parity B^C^D in rounds 20 to 39 and 60 to 79.
- R4: The additive constant is 5A827999 in rounds 0 to 19, 6ED9EBA1 in rounds 20 to 39, 8F1BBCDC in rounds 40 to 59 and CA62C1D6 in rounds 60 to 79 (hex).
- R5: Each round sets A to f + E + rotl(A,5) + W + K mod 2^32, B to old A, C to rotl(old B,30), D to old C, and E to old D. A block runs exactly 80 rounds.
- R6: After round 79, each working word is added mod 2^32 to its chaining word. `cv_o` carries H0 in bits 159:128 down to H4 in bits 31:0.
- R7: While not busy, with `start_i` low, `cv_init_i` loads 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0 into H0..H4 on the next edge. It takes priority over `cv_load_i`.
- R8: While not busy, with `start_i` and `cv_init_i` low, `cv_load_i` copies `cv_i` into the chaining value on the next edge.
- R9: `start_i`, `cv_init_i` and `cv_load_i` have no effect while busy. In the cycle a start is accepted, both chaining-value controls are ignored, and the block uses the chaining value held before that edge.
- R10: `busy_o` is high for exactly 81 cycles (80 rounds and one finalize cycle) after an accepted start. `cv_o` does not change while busy except at the finalize edge.
- R11: `done_o` is high for one cycle, the cycle after `busy_o` falls, with the new chaining value on `cv_o`. A start in that cycle is accepted.
- R12: After reset, `busy_o` and `done_o` are low and `cv_o` holds the standard initial constants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin compressing `block_i` |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| cv_init_i | input | 1 | Load the standard initial chaining value |
| cv_load_i | input | 1 | Load `cv_i` as the chaining value |
| cv_i | input | 160 | Chaining value to load, H0 in the top bits |
| busy_o | output | 1 | Rounds or finalize in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cv_o | output | 160 | Current chaining value / digest |

## Verification
The bench builds the core with the default `INIT_CV` parameter, the standard SHA-1 initial value. This lets reset, the init control and the two published test messages be checked against their known digests without an explicit load. The known digests are those of the three-byte message "abc" and of the 56-byte message that spans two blocks. Random blocks from arbitrary loaded chaining values then exercise every round range, constant and schedule index. The bench also times back-to-back starts in the completion cycle and control inputs pulsed during the rounds.

// File: rtl/sha1_pkg.sv
`timescale 1ns/1ps
package sha1_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MSG_WORDS = 16;
    localparam int unsigned CV_WORDS  = 5;
    localparam int unsigned ROUNDS    = 80;
    localparam int unsigned PHASE_LEN = 20;
    localparam int unsigned BLOCK_W   = WORD_W * MSG_WORDS;
    localparam int unsigned CV_W      = WORD_W * CV_WORDS;
    localparam int unsigned RND_W     = $clog2(ROUNDS);
    localparam int unsigned IDX_W     = $clog2(MSG_WORDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } work_t;

    typedef enum logic [1:0] {
        PH_CHOOSE = 2'd0,
        PH_PARITY_LO = 2'd1,
        PH_MAJORITY = 2'd2,
        PH_PARITY_HI = 2'd3
    } phase_t;

    localparam logic [CV_W-1:0] SHA1_IV =
        {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic phase_t phase_of(input logic [RND_W-1:0] rnd);
        if (rnd < RND_W'(PHASE_LEN))          return PH_CHOOSE;
        else if (rnd < RND_W'(2 * PHASE_LEN)) return PH_PARITY_LO;
        else if (rnd < RND_W'(3 * PHASE_LEN)) return PH_MAJORITY;
        else                                   return PH_PARITY_HI;
    endfunction

    function automatic word_t mix_fn(input phase_t ph, input word_t b, input word_t c,
                                     input word_t d);
        word_t r;
        unique case (ph)
            PH_CHOOSE:   r = d ^ (b & (c ^ d));
            PH_MAJORITY: r = (b & c) | (d & (b ^ c));
            default:     r = b ^ c ^ d;
        endcase
        return r;
    endfunction

    function automatic word_t add_const(input phase_t ph);
        word_t r;
        unique case (ph)
            PH_CHOOSE:    r = 32'h5A827999;
            PH_PARITY_LO: r = 32'h6ED9EBA1;
            PH_MAJORITY:  r = 32'h8F1BBCDC;
            default:      r = 32'hCA62C1D6;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sha1_ctrl.sv
`timescale 1ns/1ps
module sha1_ctrl
    import sha1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cv_init_i,
    input  logic             cv_load_i,
    output logic [RND_W-1:0] rnd_o,
    output logic             blk_load_o,
    output logic             step_o,
    output logic             fin_o,
    output logic             iv_en_o,
    output logic             cv_en_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_FINAL = 2'd2,
        ST_DONE  = 2'd3
    } st_t;

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    st_t              state_q, state_d;
    logic [RND_W-1:0] rnd_q;
    logic             ready;
    logic             accept;

    assign ready  = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign accept = ready && start_i;

    // state register and round index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                rnd_q <= '0;
            else if (state_q == ST_ROUND && rnd_q != LAST_RND)
                rnd_q <= rnd_q + RND_W'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start_i ? ST_ROUND : ST_IDLE;
            ST_ROUND: state_d = (rnd_q == LAST_RND) ? ST_FINAL : ST_ROUND;
            ST_FINAL: state_d = ST_DONE;
            ST_DONE:  state_d = start_i ? ST_ROUND : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        done_o     = 1'b0;
        step_o     = 1'b0;
        fin_o      = 1'b0;
        blk_load_o = accept;
        iv_en_o    = ready && !start_i && cv_init_i;
        cv_en_o    = ready && !start_i && !cv_init_i && cv_load_i;
        unique case (state_q)
            ST_ROUND: begin
                busy_o = 1'b1;
                step_o = 1'b1;
            end
            ST_FINAL: begin
                busy_o = 1'b1;
                fin_o  = 1'b1;
            end
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
    end

    assign rnd_o = rnd_q;

endmodule

// File: rtl/sha1_sched.sv
`timescale 1ns/1ps
module sha1_sched
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               load_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic               step_i,
    input  logic [RND_W-1:0]   rnd_i,
    output word_t              w_o
);

    localparam logic [IDX_W-1:0] TAP3  = IDX_W'(3);
    localparam logic [IDX_W-1:0] TAP8  = IDX_W'(8);
    localparam logic [IDX_W-1:0] TAP14 = IDX_W'(14);

    word_t            win [MSG_WORDS];
    logic [IDX_W-1:0] i_cur, i_m3, i_m8, i_m14;
    word_t            expanded;

    // circular window: slot i mod 16 holds W[i-16] at round i
    assign i_cur = rnd_i[IDX_W-1:0];
    assign i_m3  = i_cur - TAP3;
    assign i_m8  = i_cur - TAP8;
    assign i_m14 = i_cur - TAP14;

    assign expanded = rotl(win[i_m3] ^ win[i_m8] ^ win[i_m14] ^ win[i_cur], 1);
    assign w_o      = (rnd_i < RND_W'(MSG_WORDS)) ? win[i_cur] : expanded;

    always_ff @(posedge clk) begin
        for (int j = 0; j < MSG_WORDS; j++) begin
            if (load_i)
                win[j] <= block_i[BLOCK_W-1-j*WORD_W -: WORD_W];
            else if (step_i && i_cur == IDX_W'(j))
                win[j] <= w_o;
        end
    end

endmodule

// File: rtl/sha1_round.sv
`timescale 1ns/1ps
module sha1_round
    import sha1_pkg::*;
(
    input  work_t            cur_i,
    input  word_t            w_i,
    input  logic [RND_W-1:0] rnd_i,
    output work_t            nxt_o
);

    phase_t ph;
    word_t  f_val;
    word_t  k_val;

    assign ph    = phase_of(rnd_i);
    assign f_val = mix_fn(ph, cur_i.b, cur_i.c, cur_i.d);
    assign k_val = add_const(ph);

    always_comb begin
        nxt_o.a = f_val + cur_i.e + rotl(cur_i.a, 5) + w_i + k_val;
        nxt_o.b = cur_i.a;
        nxt_o.c = rotl(cur_i.b, 30);
        nxt_o.d = cur_i.c;
        nxt_o.e = cur_i.d;
    end

endmodule

// File: rtl/sha1_compress_core.sv
`timescale 1ns/1ps
module sha1_compress_core
    import sha1_pkg::*;
#(
    parameter logic [CV_W-1:0] INIT_CV = SHA1_IV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic               cv_init_i,
    input  logic               cv_load_i,
    input  logic [CV_W-1:0]    cv_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [CV_W-1:0]    cv_o
);

    logic [RND_W-1:0] rnd;
    logic             blk_load;
    logic             step;
    logic             fin;
    logic             iv_en;
    logic             cv_en;
    word_t            w_cur;
    work_t            hv_q;
    work_t            wk_q;
    work_t            wk_nxt;
    work_t            sum;

    sha1_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cv_init_i  (cv_init_i),
        .cv_load_i  (cv_load_i),
        .rnd_o      (rnd),
        .blk_load_o (blk_load),
        .step_o     (step),
        .fin_o      (fin),
        .iv_en_o    (iv_en),
        .cv_en_o    (cv_en),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    sha1_sched u_sched (
        .clk     (clk),
        .load_i  (blk_load),
        .block_i (block_i),
        .step_i  (step),
        .rnd_i   (rnd),
        .w_o     (w_cur)
    );

    sha1_round u_round (
        .cur_i (wk_q),
        .w_i   (w_cur),
        .rnd_i (rnd),
        .nxt_o (wk_nxt)
    );

    always_comb begin
        sum.a = hv_q.a + wk_q.a;
        sum.b = hv_q.b + wk_q.b;
        sum.c = hv_q.c + wk_q.c;
        sum.d = hv_q.d + wk_q.d;
        sum.e = hv_q.e + wk_q.e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hv_q <= work_t'(INIT_CV);
        else if (fin)
            hv_q <= sum;
        else if (iv_en)
            hv_q <= work_t'(INIT_CV);
        else if (cv_en)
            hv_q <= work_t'(cv_i);
    end

    always_ff @(posedge clk) begin
        if (blk_load)
            wk_q <= hv_q;
        else if (step)
            wk_q <= wk_nxt;
    end

    assign cv_o = hv_q;

endmodule

// File: rtl/sha1_core_checker.sv
`timescale 1ns/1ps
module sha1_core_checker
    import sha1_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            cv_init_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [CV_W-1:0] cv_o,
    input logic [CV_W-1:0] init_cv
);

    localparam int unsigned BUSY_LEN = ROUNDS + 1;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (busy_o)
            busy_cnt <= busy_cnt + 8'd1;
        else
            busy_cnt <= '0;
    end

    assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o)) |-> busy_cnt == 8'(BUSY_LEN));

    assert_cv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cv_o));

    assert_start_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_init_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && cv_init_i) |=> cv_o == init_cv);

endmodule

bind sha1_compress_core sha1_core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cv_init_i (cv_init_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cv_o      (cv_o),
    .init_cv   (INIT_CV)
);

// File: tb/sha1_compress_core_test.sv
`timescale 1ns/1ps
module sha1_compress_core_test;

    localparam logic [159:0] IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                   32'h10325476, 32'hC3D2E1F0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         cv_init_i = 1'b0;
    logic         cv_load_i = 1'b0;
    logic [159:0] cv_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [159:0] cv_o;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;

    always #10 clk = ~clk;

    sha1_compress_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .block_i   (block_i),
        .cv_init_i (cv_init_i),
        .cv_load_i (cv_load_i),
        .cv_i      (cv_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .cv_o      (cv_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // independent reference of one compression
    function automatic logic [159:0] ref_compress(input logic [159:0] cv, input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] h [5];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 5; i++) h[i] = cv[159-32*i -: 32];
        for (int i = 0; i < 80; i++) begin
            if (i < 16) w[i] = blk[511-32*i -: 32];
            else        w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        end
        a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[0] + a, h[1] + b, h[2] + c, h[3] + d, h[4] + e};
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [159:0] rand_cv();
        logic [159:0] r;
        for (int i = 0; i < 5; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge with the core ready; returns at the negedge where done is seen.
    // inject: pulse every control input mid-run; with_load: cv_load_i together with start.
    task automatic run_block(input logic [511:0] blk, input bit inject, input bit with_load,
                             input logic [159:0] exp, input string req);
        int cnt;
        start_i   = 1'b1;
        block_i   = blk;
        cv_load_i = with_load;
        cv_i      = rand_cv();
        @(negedge clk);
        start_i   = 1'b0;
        cv_load_i = 1'b0;
        block_i   = rand_block();
        cnt = 0;
        while (busy_o && cnt < 200) begin
            if (inject && cnt == 10) begin
                start_i = 1'b1; cv_load_i = 1'b1; cv_init_i = 1'b1; cv_i = rand_cv();
            end else if (inject && cnt == 11) begin
                start_i = 1'b0; cv_load_i = 1'b0; cv_init_i = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        check(cnt == 81, "R10 busy length", 160'(cnt), 160'(81));
        check(done_o == 1'b1, "R11 done after busy", 160'(done_o), 160'(1));
        check(cv_o == exp, req, cv_o, exp);
    endtask

    task automatic check_done_drop();
        logic [159:0] held;
        held = cv_o;
        @(negedge clk);
        check(done_o == 1'b0, "R11 done one cycle", 160'(done_o), 160'(0));
        check(cv_o == held, "R11 cv held after done", cv_o, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [159:0] cv_model;
        logic [159:0] mid;
        logic [511:0] b1, b2, abc;
        logic [447:0] msg2;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R12 busy low in reset", 160'(busy_o), 160'(0));
        check(done_o == 1'b0, "R12 done low in reset", 160'(done_o), 160'(0));
        check(cv_o == IV, "R12 cv is initial value", cv_o, IV);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6: single-block "abc"
        abc = {"abc", 8'h80, 416'h0, 64'd24};
        run_block(abc, 1'b0, 1'b0, {32'ha9993e36, 32'h4706816a, 32'hba3e2571,
                  32'h7850c26c, 32'h9cd0d89d}, "R1 R6 abc digest");
        check_done_drop();

        // R7: init has priority over load
        cv_init_i = 1'b1; cv_load_i = 1'b1; cv_i = rand_cv();
        @(negedge clk);
        cv_init_i = 1'b0; cv_load_i = 1'b0;
        check(cv_o == IV, "R7 init over load", cv_o, IV);

        // two-block message, second start accepted in the done cycle (R11)
        msg2 = "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq";
        b1 = {msg2, 32'h80000000, 32'h0};
        b2 = {448'h0, 64'd448};
        mid = ref_compress(IV, b1);
        run_block(b1, 1'b0, 1'b0, mid, "R5 first of two blocks");
        run_block(b2, 1'b0, 1'b0, {32'h84983e44, 32'h1c3bd26e, 32'hbaae4aa1,
                  32'hf95129e5, 32'he54670f1}, "R6 R11 two-block digest");
        check_done_drop();

        // R8: arbitrary chaining value
        cv_model = rand_cv();
        cv_load_i = 1'b1; cv_i = cv_model;
        @(negedge clk);
        cv_load_i = 1'b0;
        check(cv_o == cv_model, "R8 load cv", cv_o, cv_model);

        // random blocks chained from the loaded value (R2 R3 R4 all round ranges)
        for (int n = 0; n < 12; n++) begin
            b1 = rand_block();
            cv_model = ref_compress(cv_model, b1);
            run_block(b1, (n % 3) == 1, (n % 4) == 2, cv_model, "R2 R3 R4 random block");
            if (n % 2 == 0) check_done_drop();
        end

        // R9: controls ignored while busy and when start wins
        b1 = rand_block();
        cv_model = ref_compress(cv_model, b1);
        run_block(b1, 1'b1, 1'b1, cv_model, "R9 controls ignored");
        check_done_drop();

        // directed corner: all-zero block from zero chaining value
        cv_load_i = 1'b1; cv_i = '0;
        @(negedge clk);
        cv_load_i = 1'b0;
        run_block('0, 1'b0, 1'b0, ref_compress('0, '0), "R5 zero block");
        check_done_drop();

        // directed corner: all-ones block from all-ones value
        cv_load_i = 1'b1; cv_i = '1;
        @(negedge clk);
        cv_load_i = 1'b0;
        run_block('1, 1'b0, 1'b0, ref_compress('1, '1), "R6 all-ones block");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule